// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a small bidirectional binary counter. It takes two separate count strobes: one advances the value and the other retreats it. There is no shared clock and direction bit. A free-running system clock passes each strobe through a synchronizer and watches for its low-to-high transitions. A strobe edge moves the count only while the other strobe rests high.

A parallel preset path is enabled by an active-low load level. An active-high clear level sends the value to zero and beats both load and counting. Clear and load act on the system clock edge.

Two active-low cascade flags, `carry_n` and `borrow_n`, idle high like the strobes. A flag follows the low phase of its strobe while the count sits at its top or bottom value. It can therefore drive the matching strobe of the next stage directly, which lets stages be chained into a wider counter with no extra logic.

Top module: `updn_dual_strobe_counter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count` is 0 and both `carry_n` and `borrow_n` are 1, given both strobes rest high.
- R2: A low-to-high transition of `up_strb` adds one to `count`, provided `dn_strb` is high. The new value appears by the third system clock edge after the strobe rises.
- R3: A low-to-high transition of `dn_strb` subtracts one from `count`, provided `up_strb` is high. The timing is the same as R2.
- R4: A rising strobe is ignored while the other strobe is low. `count` stays unchanged for that edge.
- R5: When both strobes rise in the same sampled cycle, `count` does not change.
- R6: While `load_n` is 0 and `clr` is 0, `count` takes the value of `preset` on the next clock edge, whatever the strobes do.
- R7: While `clr` is 1, `count` becomes 0 on the next clock edge. This holds regardless of `load_n` and of the strobes.
- R8: Counting wraps modulo 2^WIDTH: the top value plus one gives 0, and 0 minus one gives the top value.
- R9: `carry_n` is 0 exactly while the synchronized `up_strb` is low and `count` is all ones. Otherwise it is 1.
- R10: `borrow_n` is 0 exactly while the synchronized `dn_strb` is low and `count` is 0. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst | input | 1 | Synchronous active-high reset |
| up_strb | input | 1 | Count-up strobe, idle high, acts on rising edge |
| dn_strb | input | 1 | Count-down strobe, idle high, acts on rising edge |
| load_n | input | 1 | Active-low level that loads `preset` |
| clr | input | 1 | Active-high level that zeroes the count |
| preset | input | WIDTH | Parallel data for load |
| count | output | WIDTH | Current counter value |
| carry_n | output | 1 | Active-low overflow pulse for the next stage's up strobe |
| borrow_n | output | 1 | Active-low underflow pulse for the next stage's down strobe |

## Verification
A corrupted count register shows up on `count` three edges after the strobe that caused it. The error stays there until a load or clear repairs it. The cascade flags depend on that same register, so a wrong top or bottom value also bends a carry or borrow pulse, two edges after the strobe falls. Faults in priority or edge pairing surface on the edge after the offending level or strobe. To expose them, the bench holds load, clear and the opposite strobe across strobe pulses.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b10
  } step_t;
endpackage

// File: rtl/dcc_strobe_sync.sv
module dcc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strb,
  output logic lvl,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;

  // idle-high reset keeps a released strobe from looking like an edge
  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= strb;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[LAST-1:0], strb};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[LAST];
  end

  assign lvl  = chain[LAST];
  assign rise = chain[LAST] & ~prev;
endmodule

// File: rtl/dcc_step_decode.sv
module dcc_step_decode
  import dcc_pkg::*;
(
  input  logic  up_rise,
  input  logic  dn_rise,
  input  logic  up_lvl,
  input  logic  dn_lvl,
  output step_t step
);
  always_comb begin
    step = STEP_HOLD;
    if (up_rise && !dn_rise && dn_lvl)      step = STEP_UP;
    else if (dn_rise && !up_rise && up_lvl) step = STEP_DN;
  end
endmodule

// File: rtl/dcc_count_reg.sv
module dcc_count_reg
  import dcc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  step_t            step,
  output logic [WIDTH-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (clr)     count <= '0;
    else if (!load_n) count <= preset;
    else begin
      case (step)
        STEP_UP: count <= count + 1'b1;
        STEP_DN: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dcc_cascade_flags.sv
module dcc_cascade_flags #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOT = '0;

  assign carry_n  = ~(~up_lvl && (count == TOP));
  assign borrow_n = ~(~dn_lvl && (count == BOT));
endmodule

// File: rtl/updn_dual_strobe_counter.sv
module updn_dual_strobe_counter
  import dcc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_strb,
  input  logic             dn_strb,
  input  logic             load_n,
  input  logic             clr,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int NCH = 2;  // channel 0 = up, channel 1 = down

  logic [NCH-1:0] strb_in;
  logic [NCH-1:0] lvl;
  logic [NCH-1:0] rise;
  logic           up_lvl, dn_lvl, up_rise, dn_rise;
  step_t          step;

  assign strb_in = {dn_strb, up_strb};

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_sync
      dcc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .strb (strb_in[g]),
        .lvl  (lvl[g]),
        .rise (rise[g])
      );
    end
  endgenerate

  assign up_lvl  = lvl[0];
  assign dn_lvl  = lvl[1];
  assign up_rise = rise[0];
  assign dn_rise = rise[1];

  dcc_step_decode u_dec (
    .up_rise (up_rise),
    .dn_rise (dn_rise),
    .up_lvl  (up_lvl),
    .dn_lvl  (dn_lvl),
    .step    (step)
  );

  dcc_count_reg #(.WIDTH(WIDTH)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .load_n (load_n),
    .preset (preset),
    .step   (step),
    .count  (count)
  );

  dcc_cascade_flags #(.WIDTH(WIDTH)) u_flags (
    .count    (count),
    .up_lvl   (up_lvl),
    .dn_lvl   (dn_lvl),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             load_n,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             up_rise,
  input logic             dn_rise
);
  localparam logic [WIDTH-1:0] TOP = '1;

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  a_r6_load_value: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (count == $past(preset)));

  // R2 and R3: without overrides the value moves by at most one step
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (clr == 1'b0 && load_n == 1'b1) |=>
      ((count == $past(count)) ||
       (count == WIDTH'($past(count) + 1'b1)) ||
       (count == WIDTH'($past(count) - 1'b1))));

  a_r5_both_rise_hold: assert property (@(posedge clk) disable iff (rst)
    (up_rise && dn_rise && !clr && load_n) |=> $stable(count));

  a_r9_carry_at_top: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (count == TOP));

  a_r10_borrow_at_zero: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (count == '0));
endmodule

bind updn_dual_strobe_counter dcc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .load_n   (load_n),
  .preset   (preset),
  .count    (count),
  .carry_n  (carry_n),
  .borrow_n (borrow_n),
  .up_rise  (up_rise),
  .dn_rise  (dn_rise)
);

// File: tb/test_updn_dual_strobe_counter.sv
module test_updn_dual_strobe_counter;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] cnt;
    logic         c;
    logic         b;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         up_strb = 1'b1;
  logic         dn_strb = 1'b1;
  logic         load_n = 1'b1;
  logic         clr = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         carry_n, borrow_n;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  updn_dual_strobe_counter #(.WIDTH(W), .SYNC_STAGES(2)) i_updn_dual_strobe_counter (
    .clk(clk), .rst(rst), .up_strb(up_strb), .dn_strb(dn_strb),
    .load_n(load_n), .clr(clr), .preset(preset),
    .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  // monitor: compares queued expectations away from the rising edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_vec++;
      if (count !== e.cnt || carry_n !== e.c || borrow_n !== e.b) begin
        n_bad++;
        $display("FAIL %s: got count=%0d carry_n=%b borrow_n=%b, expected count=%0d carry_n=%b borrow_n=%b",
                 e.tag, count, carry_n, borrow_n, e.cnt, e.c, e.b);
      end
    end
  end

  task automatic push(input logic [W-1:0] c, input logic cf, input logic bf, input string tag);
    exp_t e;
    e.cnt = c; e.c = cf; e.b = bf; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up_strb = 1'b0; ticks(4);
    up_strb = 1'b1; ticks(4);
  endtask

  task automatic pulse_dn();
    dn_strb = 1'b0; ticks(4);
    dn_strb = 1'b1; ticks(4);
  endtask

  task automatic load_val(input logic [W-1:0] v);
    preset = v; load_n = 1'b0; ticks(1);
    load_n = 1'b1; ticks(1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    ticks(5);
    push(4'd0, 1'b1, 1'b1, "R1 reset state held");
    ticks(1);
    rst = 1'b0;
    ticks(1);
    push(4'd0, 1'b1, 1'b1, "R1 after reset release");
    ticks(1);

    // R2: three up pulses
    for (int i = 1; i <= 3; i++) begin
      pulse_up();
      push(W'(i), 1'b1, 1'b1, "R2 up count");
    end

    // R3: one down pulse
    pulse_dn();
    push(4'd2, 1'b1, 1'b1, "R3 down count");

    // R4: up edge while down held low is ignored; down release then counts down
    dn_strb = 1'b0; ticks(4);
    pulse_up();
    push(4'd2, 1'b1, 1'b1, "R4 up ignored while down low");
    dn_strb = 1'b1; ticks(4);
    push(4'd1, 1'b1, 1'b1, "R3 down release after R4");

    // R5: simultaneous rise
    up_strb = 1'b0; dn_strb = 1'b0; ticks(4);
    up_strb = 1'b1; dn_strb = 1'b1; ticks(4);
    push(4'd1, 1'b1, 1'b1, "R5 both rise no change");

    // R6: load, and load overrides counting
    preset = 4'd9; load_n = 1'b0; ticks(2);
    push(4'd9, 1'b1, 1'b1, "R6 load preset");
    pulse_up();
    push(4'd9, 1'b1, 1'b1, "R6 load overrides up strobe");
    load_n = 1'b1; ticks(2);
    push(4'd9, 1'b1, 1'b1, "R6 value kept after load");

    // R7: clear beats load and strobes
    preset = 4'd5; load_n = 1'b0; clr = 1'b1; ticks(2);
    push(4'd0, 1'b1, 1'b1, "R7 clear over load");
    load_n = 1'b1;
    pulse_up();
    push(4'd0, 1'b1, 1'b1, "R7 clear over up strobe");
    clr = 1'b0; ticks(1);

    // R8/R9/R10: wrap and cascade flags
    load_val(4'd15);
    up_strb = 1'b0; ticks(4);
    push(4'd15, 1'b0, 1'b1, "R9 carry low at top");
    up_strb = 1'b1; ticks(4);
    push(4'd0, 1'b1, 1'b1, "R8 wrap up to zero");
    dn_strb = 1'b0; ticks(4);
    push(4'd0, 1'b1, 1'b0, "R10 borrow low at zero");
    dn_strb = 1'b1; ticks(4);
    push(4'd15, 1'b1, 1'b1, "R8 wrap down to top");

    load_val(4'd14);
    up_strb = 1'b0; ticks(4);
    push(4'd14, 1'b1, 1'b1, "R9 carry high below top");
    up_strb = 1'b1; ticks(4);
    push(4'd15, 1'b1, 1'b1, "R2 count to top");
    dn_strb = 1'b0; ticks(4);
    push(4'd15, 1'b1, 1'b1, "R10 borrow high above zero");
    dn_strb = 1'b1; ticks(4);
    push(4'd14, 1'b1, 1'b1, "R3 count from top");

    ticks(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule